// File: doc/BRIEF.md
# Indirect Memory Access Register Bridge

This block lets a host that only issues register (I/O-space) accesses reach memory on an external peripheral bus. The host loads a 32-bit target address a byte at a time into four address registers. It then touches a single data register. Writing that register starts an external memory write of the written byte. Reading it starts an external memory read, and the host access stalls until the byte comes back.

The external cycle itself is run by a separate bus sequencer. This bridge hands the sequencer a command: direction, address, write byte, chosen select and that select's configuration byte. It then waits for the sequencer's done pulse. Two zone configuration bytes each carry an indirect-enable flag. These flags decide whether any cycle is issued at all and which select the cycle uses.

Top module: `imb_bridge`

## Requirements
- R1: Host register indices 0, 1, 2 and 3 hold address bits 7:0, 15:8, 23:16 and 31:24 of the indirect target, and `seq_addr` presents them in that order.
- R2: An access to an address register or an unmapped index completes with `host_ready` high for exactly one cycle, at the first clock edge after the request is sampled. Address registers read back their stored value.
- R3: With indirect cycles enabled, a host write to index 4 (the data register) raises `seq_req` with `seq_we`=1, the stored address and the written byte on `seq_wdata`.
- R4: With indirect cycles enabled, a host read of index 4 raises `seq_req` with `seq_we`=0 and the stored address. The host read completes with the byte on `seq_rdata` at the sequencer's `seq_done` pulse.
- R5: While `seq_req` is high and `seq_done` has not arrived, the command fields stay stable and `host_ready` stays low. `seq_req` drops at the edge that samples `seq_done`.
- R6: Indirect cycles are enabled when bit 5 of `zone0_cfg` or of `zone1_cfg` is set. When both bits are clear, no `seq_req` is raised, a read of index 4 returns 0xFF, and a write is dropped; both complete one cycle after the request.
- R7: When both enable bits are set, the cycle uses select 0 (`seq_zone`=0) and `seq_cfg` equals `zone0_cfg`. When only the select 1 bit is set, `seq_zone`=1 and `seq_cfg` equals `zone1_cfg`.
- R8: Indirect cycles leave the address registers unchanged.
- R9: After reset `host_ready` and `seq_req` are low and all address registers read 0.
- R10: Indices 5 to 7 read 0x00, and writes to them change nothing. Any completed host write returns 0x00 on `host_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until host_ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_idx | input | 3 | Register index (0..3 address, 4 data) |
| host_wdata | input | 8 | Host write byte |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read result, valid with host_ready |
| zone0_cfg | input | 8 | Select 0 configuration, bit 5 = indirect enable |
| zone1_cfg | input | 8 | Select 1 configuration, bit 5 = indirect enable |
| seq_req | output | 1 | Memory cycle request to sequencer |
| seq_we | output | 1 | Memory cycle direction, 1 = write |
| seq_addr | output | 32 | Memory cycle address |
| seq_wdata | output | 8 | Memory write byte |
| seq_zone | output | 1 | Chosen select |
| seq_cfg | output | 8 | Configuration byte of chosen select |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_rdata | input | 8 | Byte returned by a memory read |

## Verification
The bench builds the block with its default parameters: four address bytes, an 8-bit data path and bit 5 as the enable flag. With these values it can reach every mapped index, the unmapped indices 5 to 7, and all four combinations of the two enable flags. Sequencer latencies between one and six cycles exercise the stall window and check the stability of the held command.

// File: rtl/imb_pkg.sv
package imb_pkg;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned ADDR_BYTES = 4;
    localparam int unsigned ADDR_W     = DATA_W * ADDR_BYTES;
    localparam int unsigned IDX_W      = $clog2(ADDR_BYTES + 1);
    localparam int unsigned ABYTE_W    = $clog2(ADDR_BYTES);
    localparam int unsigned CFG_W      = 8;
    localparam int unsigned EN_BIT     = 5;
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(ADDR_BYTES);

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} ctrl_st_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              zone;
        logic [CFG_W-1:0]  cfg;
    } mem_cmd_t;

    typedef struct packed {
        logic             valid;
        logic             zone;
        logic [CFG_W-1:0] cfg;
    } zone_pick_t;

    // Select 0 wins whenever its enable is set.
    function automatic zone_pick_t pick_zone(input logic [CFG_W-1:0] c0,
                                             input logic [CFG_W-1:0] c1);
        zone_pick_t p;
        p.valid = c0[EN_BIT] | c1[EN_BIT];
        p.zone  = ~c0[EN_BIT];
        p.cfg   = c0[EN_BIT] ? c0 : c1;
        return p;
    endfunction
endpackage

// File: rtl/imb_addr_regs.sv
module imb_addr_regs
    import imb_pkg::*;
#(
    parameter int unsigned NBYTES = ADDR_BYTES,
    parameter int unsigned DW     = DATA_W,
    localparam int unsigned SEL_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [SEL_W-1:0]           wr_sel,
    input  logic [DW-1:0]              wr_data,
    output logic [NBYTES-1:0][DW-1:0]  bytes_q
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[g] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(g))) begin
                bytes_q[g] <= wr_data;
            end
        end
    end

    // R8: without a host address write the registers keep their value
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(bytes_q));
endmodule

// File: rtl/imb_zone_sel.sv
module imb_zone_sel
    import imb_pkg::*;
(
    input  logic [CFG_W-1:0] cfg0,
    input  logic [CFG_W-1:0] cfg1,
    output zone_pick_t       pick
);
    always_comb pick = pick_zone(cfg0, cfg1);
endmodule

// File: rtl/imb_ctrl.sv
module imb_ctrl
    import imb_pkg::*;
#(
    parameter logic [DATA_W-1:0] OFF_FILL = 8'hFF
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              host_req,
    input  logic                              host_wr,
    input  logic [IDX_W-1:0]                  host_idx,
    input  logic [DATA_W-1:0]                 host_wdata,
    output logic                              host_ready,
    output logic [DATA_W-1:0]                 host_rdata,
    input  zone_pick_t                        pick,
    input  logic [ADDR_BYTES-1:0][DATA_W-1:0] addr_bytes,
    output logic                              addr_wr_en,
    output logic                              seq_req,
    output mem_cmd_t                          cmd_q,
    input  logic                              seq_done,
    input  logic [DATA_W-1:0]                 seq_rdata
);
    ctrl_st_e st_q;
    logic     is_addr;
    logic     is_data;
    logic [DATA_W-1:0] reg_rd;

    always_comb begin
        is_addr    = (host_idx < IDX_W'(ADDR_BYTES));
        is_data    = (host_idx == DATA_IDX);
        addr_wr_en = (st_q == ST_IDLE) && host_req && host_wr && is_addr;
        reg_rd     = is_addr ? addr_bytes[host_idx[ABYTE_W-1:0]] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            host_ready <= 1'b0;
            host_rdata <= '0;
            seq_req    <= 1'b0;
            cmd_q      <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    host_ready <= 1'b0;
                    if (host_req) begin
                        if (is_data && pick.valid) begin
                            seq_req    <= 1'b1;
                            cmd_q.we   <= host_wr;
                            cmd_q.addr <= addr_bytes;
                            cmd_q.data <= host_wr ? host_wdata : '0;
                            cmd_q.zone <= pick.zone;
                            cmd_q.cfg  <= pick.cfg;
                            st_q       <= ST_BUSY;
                        end else begin
                            if (host_wr)      host_rdata <= '0;
                            else if (is_data) host_rdata <= OFF_FILL;
                            else              host_rdata <= reg_rd;
                            host_ready <= 1'b1;
                            st_q       <= ST_RESP;
                        end
                    end
                end
                ST_BUSY: begin
                    if (seq_done) begin
                        seq_req    <= 1'b0;
                        host_rdata <= cmd_q.we ? '0 : seq_rdata;
                        host_ready <= 1'b1;
                        st_q       <= ST_RESP;
                    end
                end
                default: begin
                    host_ready <= 1'b0;
                    st_q       <= ST_IDLE;
                end
            endcase
        end
    end

    // R5: the command is held unchanged until the sequencer finishes
    p_cmd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_req && !seq_done) |=> (seq_req && $stable(cmd_q)));
    // R5: no host completion while a memory cycle is outstanding
    p_stall_r5: assert property (@(posedge clk) disable iff (rst)
        seq_req |-> !host_ready);
    // R5: done ends the request at the next edge
    p_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (seq_req && seq_done) |=> !seq_req);
    // R2: completion is a single-cycle pulse
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        host_ready |=> !host_ready);
    // R6: a request starts only when an enable flag was set
    p_no_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_req) |-> $past(pick.valid));
endmodule

// File: rtl/imb_bridge.sv
module imb_bridge
    import imb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [2:0]        host_idx,
    input  logic [7:0]        host_wdata,
    output logic              host_ready,
    output logic [7:0]        host_rdata,
    input  logic [7:0]        zone0_cfg,
    input  logic [7:0]        zone1_cfg,
    output logic              seq_req,
    output logic              seq_we,
    output logic [31:0]       seq_addr,
    output logic [7:0]        seq_wdata,
    output logic              seq_zone,
    output logic [7:0]        seq_cfg,
    input  logic              seq_done,
    input  logic [7:0]        seq_rdata
);
    zone_pick_t                        pick;
    logic [ADDR_BYTES-1:0][DATA_W-1:0] addr_bytes;
    logic                              addr_wr_en;
    mem_cmd_t                          cmd;

    imb_zone_sel u_zone (
        .cfg0 (zone0_cfg),
        .cfg1 (zone1_cfg),
        .pick (pick)
    );

    imb_addr_regs #(.NBYTES(ADDR_BYTES), .DW(DATA_W)) u_addr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (addr_wr_en),
        .wr_sel  (host_idx[ABYTE_W-1:0]),
        .wr_data (host_wdata),
        .bytes_q (addr_bytes)
    );

    imb_ctrl #(.OFF_FILL(8'hFF)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_wr    (host_wr),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_ready (host_ready),
        .host_rdata (host_rdata),
        .pick       (pick),
        .addr_bytes (addr_bytes),
        .addr_wr_en (addr_wr_en),
        .seq_req    (seq_req),
        .cmd_q      (cmd),
        .seq_done   (seq_done),
        .seq_rdata  (seq_rdata)
    );

    always_comb begin
        seq_we    = cmd.we;
        seq_addr  = cmd.addr;
        seq_wdata = cmd.data;
        seq_zone  = cmd.zone;
        seq_cfg   = cmd.cfg;
    end

    // R7: select 0 has priority; select 1 only when select 0 is off
    p_zone_prio_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_req) |-> (seq_zone == !$past(zone0_cfg[EN_BIT])));
endmodule

// File: tb/imb_bridge_tb_top.sv
module imb_bridge_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_req = 1'b0, host_wr = 1'b0;
    logic [2:0] host_idx = '0;
    logic [7:0] host_wdata = '0;
    logic host_ready;
    logic [7:0] host_rdata;
    logic [7:0] zone0_cfg = '0, zone1_cfg = '0;
    logic seq_req, seq_we, seq_zone;
    logic [31:0] seq_addr;
    logic [7:0] seq_wdata, seq_cfg;
    logic seq_done = 1'b0;
    logic [7:0] seq_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    imb_bridge dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .zone0_cfg(zone0_cfg), .zone1_cfg(zone1_cfg),
        .seq_req(seq_req), .seq_we(seq_we), .seq_addr(seq_addr),
        .seq_wdata(seq_wdata), .seq_zone(seq_zone), .seq_cfg(seq_cfg),
        .seq_done(seq_done), .seq_rdata(seq_rdata)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] m_addr [4];

    // sequencer model observations
    int   seq_starts = 0, seq_unstable = 0;
    logic s_we, s_zone; logic [31:0] s_addr; logic [7:0] s_wdata, s_cfg, s_ret;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_en(input logic [7:0] c0, input logic [7:0] c1);
        return c0[5] | c1[5];
    endfunction
    function automatic bit exp_zone(input logic [7:0] c0);
        return !c0[5];
    endfunction

    // sequencer: random latency 1..6, random read data
    initial begin
        int cnt = 0; bit busy = 0;
        forever begin
            @(negedge clk);
            seq_done = 1'b0;
            if (seq_req && !busy) begin
                busy = 1; seq_starts++;
                s_we = seq_we; s_addr = seq_addr; s_wdata = seq_wdata;
                s_zone = seq_zone; s_cfg = seq_cfg;
                cnt = 1 + int'($urandom_range(5));
            end
            if (busy && seq_req) begin
                if (seq_we != s_we || seq_addr != s_addr || seq_wdata != s_wdata ||
                    seq_zone != s_zone || seq_cfg != s_cfg) seq_unstable++;
                if (cnt == 0) begin
                    s_ret = 8'($urandom());
                    seq_rdata = s_ret;
                    seq_done = 1'b1;
                    busy = 0;
                end else cnt--;
            end
        end
    end

    task automatic access(input bit wr, input logic [2:0] idx, input logic [7:0] wd,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_idx = idx; host_wdata = wd;
        lat = 0;
        forever begin
            @(negedge clk);
            lat++;
            if (host_ready) begin rd = host_rdata; break; end
            if (lat > 100) begin chk(0, "R5 host watchdog", lat, 0); rd = 'x; break; end
        end
        host_req = 1'b0;
    endtask

    // one access with full expectation checking
    task automatic op(input bit wr, input logic [2:0] idx, input logic [7:0] wd,
                      input logic [7:0] c0, input logic [7:0] c1);
        logic [7:0] rd; int lat; int starts0; int unst0;
        zone0_cfg = c0; zone1_cfg = c1;
        starts0 = seq_starts; unst0 = seq_unstable;
        access(wr, idx, wd, rd, lat);
        if (idx < 4) begin
            if (wr) m_addr[idx] = wd;
            else chk(rd == m_addr[idx], "R1 R2 address readback", rd, m_addr[idx]);
            chk(lat == 1, "R2 register latency", lat, 1);
            chk(seq_starts == starts0, "R8 no cycle on address access", seq_starts - starts0, 0);
        end else if (idx > 4) begin
            chk(rd == 8'h00, "R10 unmapped reads zero", rd, 0);
            chk(lat == 1, "R2 unmapped latency", lat, 1);
        end else if (!exp_en(c0, c1)) begin
            chk(seq_starts == starts0, "R6 no cycle when disabled", seq_starts - starts0, 0);
            chk(rd == (wr ? 8'h00 : 8'hFF), "R6 disabled data result", rd, wr ? 0 : 8'hFF);
            chk(lat == 1, "R6 disabled latency", lat, 1);
        end else begin
            chk(seq_starts == starts0 + 1, "R3 R4 one cycle issued", seq_starts - starts0, 1);
            chk(s_we == wr, "R3 R4 direction", s_we, wr);
            chk(s_addr == {m_addr[3], m_addr[2], m_addr[1], m_addr[0]}, "R1 cycle address",
                s_addr, {m_addr[3], m_addr[2], m_addr[1], m_addr[0]});
            if (wr) begin
                chk(s_wdata == wd, "R3 write byte", s_wdata, wd);
                chk(rd == 8'h00, "R10 write returns zero", rd, 0);
            end else begin
                chk(rd == s_ret, "R4 returned byte", rd, s_ret);
            end
            chk(s_zone == exp_zone(c0), "R7 select", s_zone, exp_zone(c0));
            chk(s_cfg == (c0[5] ? c0 : c1), "R7 configuration", s_cfg, c0[5] ? c0 : c1);
            chk(seq_unstable == unst0, "R5 command stable", seq_unstable - unst0, 0);
            chk(lat >= 2, "R5 host stalled", lat, 2);
        end
    endtask

    task automatic final_report;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "global watchdog", 0, 1);
        final_report();
    end

    initial begin
        logic [7:0] rd; int lat;
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 4; i++) m_addr[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(host_ready == 0, "R9 ready low", host_ready, 0);
        chk(seq_req == 0, "R9 request low", seq_req, 0);
        for (int i = 0; i < 4; i++) op(0, 3'(i), 0, 0, 0);

        // R1 directed address load and readback
        op(1, 0, 8'h11, 0, 0); op(1, 1, 8'h22, 0, 0);
        op(1, 2, 8'h33, 0, 0); op(1, 3, 8'h44, 0, 0);
        for (int i = 0; i < 4; i++) op(0, 3'(i), 0, 0, 0);
        // R3 R7 both enabled -> select 0
        op(1, 4, 8'hA5, 8'h20, 8'h2F);
        // R4 R7 only select 1
        op(0, 4, 0, 8'h0F, 8'h21);
        // R8 address unchanged after indirect cycles
        for (int i = 0; i < 4; i++) op(0, 3'(i), 0, 0, 0);
        // R6 both disabled
        op(0, 4, 0, 8'hDF, 8'hDF);
        op(1, 4, 8'h5A, 8'h00, 8'h00);
        // R10 unmapped writes ignored
        op(1, 5, 8'hFF, 0, 0); op(1, 7, 8'hEE, 0, 0);
        op(0, 6, 0, 0, 0);
        for (int i = 0; i < 4; i++) op(0, 3'(i), 0, 0, 0);

        // random mix
        for (int n = 0; n < 400; n++) begin
            op(1'($urandom()), 3'($urandom()), 8'($urandom()),
               8'($urandom()), 8'($urandom()));
        end
        final_report();
    end
endmodule